// File: doc/BRIEF.md
# Right-to-left Montgomery exponentiation sequencer

This block computes X^E mod N by scanning the exponent from its least significant bit upward, with every intermediate value held in Montgomery residue form. It does not contain the modular multipliers. It drives two external Montgomery product units through request/done handshakes. The square unit repeatedly squares the running power Z. The multiply unit folds Z into the accumulator P whenever the current exponent bit is one. The two units run at the same time. The block owns a small register file of operands: P, Z, X, N, the precomputed constant R^2 mod N (with R = 2^(K+2)), and the constant 1. It presents operands from that file to the units and commits their results.

At start, the block latches X, N, R^2 mod N, an exponent word and an exponent length H. It then performs four phases in order:
- It converts 1 and X into residue form in one slot, using both units.
- It runs H loop iterations.
- It issues one conversion product back out of residue form.
- It runs a word-serial compare-and-subtract, so the result is fully reduced below N.

The result leaves the block as a burst of S-bit words, least significant first. Each product unit may return any value in [0, 2N) that is congruent to the true Montgomery product.

Top module: `mexp_seq`

## Requirements
- R1: After reset the block is idle: busy, sq_req, mu_req and res_valid are all low. A start pulse while idle latches x_in, n_in, r2_in, e_in and e_len, and raises busy until the last result word. A start pulse while busy is ignored and does not alter the running computation.
- R2: The first product slot issues both units in the same cycle. The square unit receives (X, R^2 mod N) and its result becomes Z. The multiply unit receives (1, R^2 mod N) and its result becomes P.
- R3: Loop iteration i, for i from 0 to H-1, issues the square unit with operands (Z, Z). The multiply unit is requested in that same cycle, with operands (P, Z), exactly when bit i of e_in is 1, where bit 0 is the least significant bit. When the bit is 0, only the square unit is requested.
- R4: In an iteration, the multiply unit receives the Z from before that iteration's squaring. No result is committed until every unit issued in the slot has pulsed done. Operands stay stable from a request until that unit's done. A unit is never re-requested before its done.
- R5: Exponent bits at positions H and above have no effect. With H = 0, the result is 1 mod N.
- R6: After the loop, the multiply unit alone receives (P, 1). A run therefore issues H+1 square requests and popcount(E restricted to H bits)+2 multiply requests, over H+2 sequential product slots.
- R7: If the converted value P is at least N, it is reduced by N. The delivered result equals X^E mod N.
- R8: The result is delivered as M = ceil((K+3)/S) words of S bits, least significant word first. The words occupy M consecutive cycles with res_valid high. res_last is high only with the final word, and res_valid is low in the cycle after it.
- R9: Count the rising clock edge that samples the done pulse of the conversion product as edge 0. The first result word is presented after edge M+2, and the last after edge 2M+1. This gives M subtraction cycles and one select cycle before the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (honoured only when idle) |
| x_in | input | K | Base X, below N |
| n_in | input | K | Odd modulus N |
| r2_in | input | K | Precomputed R^2 mod N, R = 2^(K+2) |
| e_in | input | EW | Exponent, bit 0 consumed first |
| e_len | input | clog2(EW+1) | Number H of exponent bits to use |
| busy | output | 1 | High from the cycle after start until the last word |
| sq_req | output | 1 | One-cycle request to the square unit |
| sq_opa | output | K+3 | Square unit operand A |
| sq_opb | output | K+3 | Square unit operand B |
| sq_done | input | 1 | One-cycle completion from the square unit |
| sq_res | input | K+3 | Square unit result, valid with sq_done |
| mu_req | output | 1 | One-cycle request to the multiply unit |
| mu_opa | output | K+3 | Multiply unit operand A |
| mu_opb | output | K+3 | Multiply unit operand B |
| mu_done | input | 1 | One-cycle completion from the multiply unit |
| mu_res | input | K+3 | Multiply unit result, valid with mu_done |
| res_valid | output | 1 | Result word valid |
| res_word | output | S | Result word, least significant first |
| res_last | output | 1 | Marks the final result word |

## Verification
The assertions assume that each product unit pulses done exactly once per request, for a single cycle, and never in the cycle of its own request. They also assume that N is odd, X is below N, and every product result lies in [0, 2N). The bench models both units behaviourally under those rules. Each unit uses a pseudo-random latency of 0 to 4 extra cycles, so the two units finish in either order. Each unit adds N to a reduced product either pseudo-randomly, always, or never, so that both outcomes of the final subtraction are reached. A reference model tracks P and Z from the units' own returns, and checks every request's operands against them.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

    // Register file slots; slot numbers are private to the block.
    typedef enum logic [2:0] {
        RF_P   = 3'd0,
        RF_Z   = 3'd1,
        RF_X   = 3'd2,
        RF_R2  = 3'd3,
        RF_ONE = 3'd4,
        RF_N   = 3'd5
    } rf_id_e;

    localparam int RF_NUM = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_REQ,
        ST_LOOP_CHK,
        ST_LOOP_REQ,
        ST_FIN_REQ,
        ST_WAIT,
        ST_DRAIN
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_INIT,
        OP_LOOP,
        OP_FIN
    } op_kind_e;

    typedef enum logic [1:0] {
        SO_IDLE,
        SO_SUB,
        SO_SEL,
        SO_EMIT
    } so_st_e;

    typedef struct packed {
        rf_id_e a;
        rf_id_e b;
    } opsel_t;

    function automatic int words_for(input int bits, input int s);
        return (bits + s - 1) / s;
    endfunction

endpackage

// File: rtl/mexp_regfile.sv
module mexp_regfile
    import mexp_pkg::*;
#(
    parameter int K   = 16,
    parameter int W   = K + 3,
    parameter int NRD = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [K-1:0] x_in,
    input  logic [K-1:0] n_in,
    input  logic [K-1:0] r2_in,
    input  logic         wr_p,
    input  logic [W-1:0] p_d,
    input  logic         wr_z,
    input  logic [W-1:0] z_d,
    input  rf_id_e       rsel  [NRD],
    output logic [W-1:0] rdata [NRD],
    output logic [W-1:0] p_out,
    output logic [W-1:0] n_out
);

    logic [W-1:0] mem [RF_NUM];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_NUM; i++) mem[i] <= '0;
        end else begin
            if (load) begin
                mem[RF_X]   <= {{(W-K){1'b0}}, x_in};
                mem[RF_N]   <= {{(W-K){1'b0}}, n_in};
                mem[RF_R2]  <= {{(W-K){1'b0}}, r2_in};
                mem[RF_ONE] <= W'(1);
            end
            if (wr_p) mem[RF_P] <= p_d;
            if (wr_z) mem[RF_Z] <= z_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (int'(rsel[g]) < RF_NUM) ? mem[rsel[g]] : '0;
    end

    assign p_out = mem[RF_P];
    assign n_out = mem[RF_N];

endmodule

// File: rtl/mexp_ctrl.sv
module mexp_ctrl
    import mexp_pkg::*;
#(
    parameter int W  = 19,
    parameter int EW = 32,
    parameter int LW = $clog2(EW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [EW-1:0] e_in,
    input  logic [LW-1:0] len_in,
    output logic          busy,
    output logic          load,
    output logic          sq_req,
    output logic          mu_req,
    output opsel_t        sq_sel,
    output opsel_t        mu_sel,
    input  logic          sq_done,
    input  logic [W-1:0]  sq_res,
    input  logic          mu_done,
    input  logic [W-1:0]  mu_res,
    output logic          wr_p,
    output logic [W-1:0]  p_d,
    output logic          wr_z,
    output logic [W-1:0]  z_d,
    output logic          sub_go,
    input  logic          sub_fin
);

    seq_st_e       state_q;
    op_kind_e      kind_q;
    logic [EW-1:0] e_q;
    logic [LW-1:0] len_q, cnt_q;
    logic          need_sq_q, need_mu_q, got_sq_q, got_mu_q;
    logic [W-1:0]  stg_z_q, stg_p_q;
    logic          sub_go_q;
    logic          sq_ok, mu_ok, all_ok;

    // Operand routing per slot kind
    always_comb begin
        unique case (kind_q)
            OP_INIT: begin
                sq_sel = '{a: RF_X, b: RF_R2};
                mu_sel = '{a: RF_ONE, b: RF_R2};
            end
            OP_LOOP: begin
                sq_sel = '{a: RF_Z, b: RF_Z};
                mu_sel = '{a: RF_P, b: RF_Z};
            end
            default: begin
                sq_sel = '{a: RF_Z, b: RF_Z};
                mu_sel = '{a: RF_P, b: RF_ONE};
            end
        endcase
    end

    always_comb begin
        load   = 1'b0;
        sq_req = 1'b0;
        mu_req = 1'b0;
        wr_p   = 1'b0;
        wr_z   = 1'b0;
        z_d    = got_sq_q ? stg_z_q : sq_res;
        p_d    = got_mu_q ? stg_p_q : mu_res;
        sq_ok  = !need_sq_q || got_sq_q || sq_done;
        mu_ok  = !need_mu_q || got_mu_q || mu_done;
        all_ok = sq_ok && mu_ok;
        unique case (state_q)
            ST_IDLE:     load = start;
            ST_INIT_REQ: begin sq_req = 1'b1; mu_req = 1'b1; end
            ST_LOOP_REQ: begin sq_req = 1'b1; mu_req = e_q[0]; end
            ST_FIN_REQ:  mu_req = 1'b1;
            ST_WAIT: if (all_ok) begin
                wr_z = need_sq_q;
                wr_p = need_mu_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            kind_q    <= OP_INIT;
            e_q       <= '0;
            len_q     <= '0;
            cnt_q     <= '0;
            need_sq_q <= 1'b0;
            need_mu_q <= 1'b0;
            got_sq_q  <= 1'b0;
            got_mu_q  <= 1'b0;
            stg_z_q   <= '0;
            stg_p_q   <= '0;
            sub_go_q  <= 1'b0;
        end else begin
            sub_go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    e_q     <= e_in;
                    len_q   <= len_in;
                    cnt_q   <= '0;
                    kind_q  <= OP_INIT;
                    state_q <= ST_INIT_REQ;
                end
                ST_INIT_REQ: begin
                    need_sq_q <= 1'b1;
                    need_mu_q <= 1'b1;
                    got_sq_q  <= 1'b0;
                    got_mu_q  <= 1'b0;
                    state_q   <= ST_WAIT;
                end
                ST_LOOP_CHK: begin
                    if (cnt_q == len_q) begin
                        kind_q  <= OP_FIN;
                        state_q <= ST_FIN_REQ;
                    end else begin
                        kind_q  <= OP_LOOP;
                        state_q <= ST_LOOP_REQ;
                    end
                end
                ST_LOOP_REQ: begin
                    need_sq_q <= 1'b1;
                    need_mu_q <= e_q[0];
                    got_sq_q  <= 1'b0;
                    got_mu_q  <= 1'b0;
                    state_q   <= ST_WAIT;
                end
                ST_FIN_REQ: begin
                    need_sq_q <= 1'b0;
                    need_mu_q <= 1'b1;
                    got_sq_q  <= 1'b0;
                    got_mu_q  <= 1'b0;
                    state_q   <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (sq_done) begin got_sq_q <= 1'b1; stg_z_q <= sq_res; end
                    if (mu_done) begin got_mu_q <= 1'b1; stg_p_q <= mu_res; end
                    if (all_ok) begin
                        if (kind_q == OP_FIN) begin
                            sub_go_q <= 1'b1;
                            state_q  <= ST_DRAIN;
                        end else begin
                            if (kind_q == OP_LOOP) begin
                                e_q   <= e_q >> 1;
                                cnt_q <= cnt_q + 1'b1;
                            end
                            state_q <= ST_LOOP_CHK;
                        end
                    end
                end
                ST_DRAIN: if (sub_fin) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign sub_go = sub_go_q;

    // R5: the iteration count never passes the requested length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= len_q)
        else $error("R5: iteration count beyond exponent length");

    // R1: a start seen while running never restarts the initial slot
    a_r1_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_INIT_REQ))
        else $error("R1: computation restarted while busy");

endmodule

// File: rtl/mexp_subout.sv
module mexp_subout
    import mexp_pkg::*;
#(
    parameter int W = 19,
    parameter int S = 4,
    parameter int M = words_for(W, S)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] p_val,
    input  logic [W-1:0] n_val,
    output logic         res_valid,
    output logic [S-1:0] res_word,
    output logic         res_last,
    output logic         fin
);

    localparam int WP = M * S;
    localparam int IW = $clog2(M + 1);

    so_st_e          st_q;
    logic [IW-1:0]   idx_q;
    logic            brw_q;
    logic            keep_diff_q;
    logic [WP-1:0]   diff_q;
    logic [WP-1:0]   p_ext, n_ext;
    logic [S-1:0]    p_w, n_w, d_w;
    logic [S:0]      dif;
    logic            at_end;

    assign p_ext  = WP'(p_val);
    assign n_ext  = WP'(n_val);
    assign p_w    = p_ext[idx_q*S +: S];
    assign n_w    = n_ext[idx_q*S +: S];
    assign d_w    = diff_q[idx_q*S +: S];
    assign dif    = {1'b0, p_w} - {1'b0, n_w} - {{S{1'b0}}, brw_q};
    assign at_end = (idx_q == IW'(M - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SO_IDLE;
            idx_q       <= '0;
            brw_q       <= 1'b0;
            keep_diff_q <= 1'b0;
            diff_q      <= '0;
        end else begin
            unique case (st_q)
                SO_IDLE: if (go) begin
                    st_q  <= SO_SUB;
                    idx_q <= '0;
                    brw_q <= 1'b0;
                end
                SO_SUB: begin
                    diff_q[idx_q*S +: S] <= dif[S-1:0];
                    brw_q                <= dif[S];
                    if (at_end) begin
                        idx_q <= '0;
                        st_q  <= SO_SEL;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SO_SEL: begin
                    keep_diff_q <= !brw_q;
                    st_q        <= SO_EMIT;
                end
                SO_EMIT: begin
                    if (at_end) begin
                        idx_q <= '0;
                        st_q  <= SO_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= SO_IDLE;
            endcase
        end
    end

    assign res_valid = (st_q == SO_EMIT);
    assign res_word  = !res_valid ? '0 : (keep_diff_q ? d_w : p_w);
    assign res_last  = res_valid && at_end;
    assign fin       = res_last;

    // R8: the burst closes after its final word
    a_r8_last_closes: assert property (@(posedge clk) disable iff (rst)
        res_last |=> !res_valid)
        else $error("R8: valid stayed high after the last word");

endmodule

// File: rtl/mexp_seq.sv
module mexp_seq
    import mexp_pkg::*;
#(
    parameter  int K  = 16,
    parameter  int S  = 4,
    parameter  int EW = 32,
    localparam int W  = K + 3,
    localparam int M  = words_for(K + 3, S),
    localparam int LW = $clog2(EW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [K-1:0]  x_in,
    input  logic [K-1:0]  n_in,
    input  logic [K-1:0]  r2_in,
    input  logic [EW-1:0] e_in,
    input  logic [LW-1:0] e_len,
    output logic          busy,
    output logic          sq_req,
    output logic [W-1:0]  sq_opa,
    output logic [W-1:0]  sq_opb,
    input  logic          sq_done,
    input  logic [W-1:0]  sq_res,
    output logic          mu_req,
    output logic [W-1:0]  mu_opa,
    output logic [W-1:0]  mu_opb,
    input  logic          mu_done,
    input  logic [W-1:0]  mu_res,
    output logic          res_valid,
    output logic [S-1:0]  res_word,
    output logic          res_last
);

    logic         load, wr_p, wr_z, sub_go, sub_fin;
    logic [W-1:0] p_d, z_d, p_val, n_val;
    opsel_t       sq_sel, mu_sel;
    rf_id_e       rd_sel [4];
    logic [W-1:0] rd_dat [4];

    mexp_ctrl #(.W(W), .EW(EW), .LW(LW)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .e_in(e_in), .len_in(e_len),
        .busy(busy), .load(load), .sq_req(sq_req), .mu_req(mu_req),
        .sq_sel(sq_sel), .mu_sel(mu_sel),
        .sq_done(sq_done), .sq_res(sq_res), .mu_done(mu_done), .mu_res(mu_res),
        .wr_p(wr_p), .p_d(p_d), .wr_z(wr_z), .z_d(z_d),
        .sub_go(sub_go), .sub_fin(sub_fin)
    );

    assign rd_sel[0] = sq_sel.a;
    assign rd_sel[1] = sq_sel.b;
    assign rd_sel[2] = mu_sel.a;
    assign rd_sel[3] = mu_sel.b;

    mexp_regfile #(.K(K), .W(W), .NRD(4)) rf_i (
        .clk(clk), .rst(rst), .load(load),
        .x_in(x_in), .n_in(n_in), .r2_in(r2_in),
        .wr_p(wr_p), .p_d(p_d), .wr_z(wr_z), .z_d(z_d),
        .rsel(rd_sel), .rdata(rd_dat), .p_out(p_val), .n_out(n_val)
    );

    assign sq_opa = rd_dat[0];
    assign sq_opb = rd_dat[1];
    assign mu_opa = rd_dat[2];
    assign mu_opb = rd_dat[3];

    mexp_subout #(.W(W), .S(S), .M(M)) sub_i (
        .clk(clk), .rst(rst), .go(sub_go), .p_val(p_val), .n_val(n_val),
        .res_valid(res_valid), .res_word(res_word), .res_last(res_last),
        .fin(sub_fin)
    );

    // Outstanding-request tracking for the handshake properties
    logic sq_out, mu_out;
    always_ff @(posedge clk) begin
        if (rst) begin
            sq_out <= 1'b0;
            mu_out <= 1'b0;
        end else begin
            if (sq_req) sq_out <= 1'b1; else if (sq_done) sq_out <= 1'b0;
            if (mu_req) mu_out <= 1'b1; else if (mu_done) mu_out <= 1'b0;
        end
    end

    // R4: no second request to a unit that has not answered
    a_r4_sq_single: assert property (@(posedge clk) disable iff (rst)
        sq_req |-> !sq_out)
        else $error("R4: square unit re-requested");
    a_r4_mu_single: assert property (@(posedge clk) disable iff (rst)
        mu_req |-> !mu_out)
        else $error("R4: multiply unit re-requested");

    // R4: operands held while a unit is working
    a_r4_sq_hold: assert property (@(posedge clk) disable iff (rst)
        (sq_req || (sq_out && !sq_done)) |=> ($stable(sq_opa) && $stable(sq_opb)))
        else $error("R4: square operands moved while outstanding");
    a_r4_mu_hold: assert property (@(posedge clk) disable iff (rst)
        (mu_req || (mu_out && !mu_done)) |=> ($stable(mu_opa) && $stable(mu_opb)))
        else $error("R4: multiply operands moved while outstanding");

endmodule

// File: tb/mexp_seq_tb_top.sv
module mexp_seq_tb_top;

    localparam int K          = 16;
    localparam int S          = 4;
    localparam int EW         = 32;
    localparam int W          = K + 3;
    localparam int M          = (W + S - 1) / S;
    localparam int LW         = $clog2(EW + 1);
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [K-1:0]  x_in = '0, n_in = '0, r2_in = '0;
    logic [EW-1:0] e_in = '0;
    logic [LW-1:0] e_len = '0;
    logic          busy, sq_req, mu_req, res_valid, res_last;
    logic [W-1:0]  sq_opa, sq_opb, mu_opa, mu_opb;
    logic          sq_done = 1'b0, mu_done = 1'b0;
    logic [W-1:0]  sq_res = '0, mu_res = '0;
    logic [S-1:0]  res_word;

    mexp_seq #(.K(K), .S(S), .EW(EW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in), .n_in(n_in),
        .r2_in(r2_in), .e_in(e_in), .e_len(e_len), .busy(busy),
        .sq_req(sq_req), .sq_opa(sq_opa), .sq_opb(sq_opb),
        .sq_done(sq_done), .sq_res(sq_res),
        .mu_req(mu_req), .mu_opa(mu_opa), .mu_opb(mu_opb),
        .mu_done(mu_done), .mu_res(mu_res),
        .res_valid(res_valid), .res_word(res_word), .res_last(res_last)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Reference state
    longint cur_n, rinv, cur_x, cur_r2, mz, mp, pend_z, pend_p, exp_res, got_res;
    bit     has_pz, has_pp, armed, sq_busy, mu_busy, mu_final;
    logic [EW-1:0] cur_e;
    int     cur_len, phase, iter, n_sq, n_mu, words_seen, tcount, mode, lf;
    int     sq_wait, mu_wait;
    longint sq_val, mu_val;

    function automatic int rnd();
        lf = lf * 1103515245 + 12345;
        return (lf >>> 8) & 32'h7fff;
    endfunction

    // Behavioural Montgomery product; result in [0, 2N)
    function automatic longint monpro(input longint a, input longint b);
        longint t;
        bit add_n;
        t = ((a % cur_n) * (b % cur_n)) % cur_n;
        t = (t * rinv) % cur_n;
        add_n = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : bit'(rnd() & 1);
        if (add_n) t = t + cur_n;
        return t;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (armed) tcount++;
        if (cyc > WD_LIMIT) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Reference model check and unit stubs, evaluated away from the active edge
    always @(negedge clk) begin
        sq_done <= 1'b0;
        mu_done <= 1'b0;
        if (!rst && (sq_req || mu_req)) begin
            if (has_pz) mz = pend_z;
            if (has_pp) mp = pend_p;
            has_pz = 0; has_pp = 0;
            if (sq_req) n_sq++;
            if (mu_req) n_mu++;
            if (phase == 0) begin
                chk(sq_req && mu_req, "R2", "both units in first slot", {sq_req, mu_req}, 3);
                chk(sq_opa == cur_x && sq_opb == cur_r2, "R2", "square operands",
                    sq_opa, cur_x);
                chk(mu_opa == 1 && mu_opb == cur_r2, "R2", "multiply operands",
                    mu_opa, 1);
                phase = 1; iter = 0; mu_final = 0;
            end else if (phase == 1 && sq_req) begin
                chk(iter < cur_len, "R5", "iteration within length", iter, cur_len);
                chk(sq_opa == mz && sq_opb == mz, "R3", "square operands", sq_opa, mz);
                chk(mu_req == cur_e[iter % EW], "R3", "multiply follows bit",
                    mu_req, cur_e[iter % EW]);
                if (mu_req) begin
                    chk(mu_opa == mp, "R3", "multiply operand P", mu_opa, mp);
                    chk(mu_opb == mz, "R4", "multiply uses pre-square Z", mu_opb, mz);
                end
                iter++;
            end else if (phase == 1) begin
                chk(iter == cur_len, "R5", "conversion after H iterations", iter, cur_len);
                chk(mu_opa == mp && mu_opb == 1, "R6", "conversion operands", mu_opb, 1);
                phase = 2; mu_final = 1;
            end else begin
                chk(0, "R6", "request after conversion", phase, 1);
            end
        end
        if (sq_busy) begin
            if (sq_wait == 0) begin
                sq_done <= 1'b1; sq_res <= W'(sq_val); sq_busy = 0;
            end else sq_wait--;
        end else if (sq_req) begin
            sq_val = monpro(sq_opa, sq_opb); pend_z = sq_val; has_pz = 1;
            sq_wait = rnd() % 5; sq_busy = 1;
        end
        if (mu_busy) begin
            if (mu_wait == 0) begin
                mu_done <= 1'b1; mu_res <= W'(mu_val); mu_busy = 0;
                if (mu_final) begin tcount = 0; armed = 1; end
            end else mu_wait--;
        end else if (mu_req) begin
            mu_val = monpro(mu_opa, mu_opb); pend_p = mu_val; has_pp = 1;
            mu_wait = rnd() % 5; mu_busy = 1;
        end
        if (!rst && res_valid) begin
            if (words_seen == 0)
                chk(tcount == M + 3, "R9", "first word timing", tcount, M + 3);
            if (words_seen == M - 1)
                chk(tcount == 2 * M + 2, "R9", "last word timing", tcount, 2 * M + 2);
            chk(res_word == ((exp_res >> (words_seen * S)) & ((1 << S) - 1)), "R7",
                "result word", res_word, (exp_res >> (words_seen * S)) & ((1 << S) - 1));
            chk(res_last == (words_seen == M - 1), "R8", "last flag", res_last,
                words_seen == M - 1);
            got_res = got_res | (longint'(res_word) << (words_seen * S));
            words_seen++;
        end
    end

    task automatic run_case(input longint n, input longint x, input logic [EW-1:0] e,
                            input int len, input int md, input bit poke);
        longint inv2, r, b, ee;
        int pc;
        inv2 = (n + 1) / 2;
        rinv = 1; r = 1;
        for (int i = 0; i < K + 2; i++) begin
            rinv = (rinv * inv2) % n;
            r = (r * 2) % n;
        end
        cur_n = n; cur_x = x; cur_r2 = (r * r) % n; cur_e = e; cur_len = len; mode = md;
        exp_res = 1 % n; b = x % n; pc = 0;
        for (int i = 0; i < len; i++) begin
            if (e[i]) begin exp_res = (exp_res * b) % n; pc++; end
            b = (b * b) % n;
        end
        phase = 0; n_sq = 0; n_mu = 0; words_seen = 0; armed = 0; got_res = 0;
        has_pz = 0; has_pp = 0;
        @(negedge clk);
        x_in = K'(x); n_in = K'(n); r2_in = K'(cur_r2); e_in = e; e_len = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        if (poke) begin
            repeat (9) @(negedge clk);
            x_in = K'(x ^ 5); e_in = ~e; e_len = LW'(3); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (words_seen < M) @(negedge clk);
        @(negedge clk);
        ee = pc;
        chk(busy == 1'b0, "R1", "idle after last word", busy, 0);
        chk(words_seen == M, "R8", "word count", words_seen, M);
        chk(n_sq == len + 1, "R6", "square requests", n_sq, len + 1);
        chk(n_mu == ee + 2, "R6", "multiply requests", n_mu, ee + 2);
        chk(got_res == exp_res, poke ? "R1" : "R7", "assembled result", got_res, exp_res);
    endtask

    initial begin
        lf = 7;
        sq_busy = 0; mu_busy = 0; armed = 0; words_seen = 0; phase = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !sq_req && !mu_req && !res_valid, "R1", "reset state",
            {busy, sq_req, mu_req, res_valid}, 0);
        rst = 1'b0;
        run_case(40961, 12345, 32'h1, 1, 0, 0);           // E = 1
        run_case(65521, 54321, 32'h10001, 17, 0, 0);      // E = 2^16+1
        run_case(65521, 0, 32'h1B, 5, 0, 0);              // X = 0
        run_case(40961, 777, 32'hFF, 0, 0, 0);            // R5: H = 0 gives 1
        run_case(50021, 31337, 32'hFFFF_FFA5, 6, 0, 0);   // R5: high bits ignored
        run_case(65535, 65000, 32'hDEAD_BEEF, 32, 1, 0);  // R7: always >= N path
        run_case(3, 2, 32'h5, 3, 2, 0);                   // R7: never >= N path
        run_case(65521, 4242, 32'h2D, 6, 0, 1);           // R1: start while busy
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule